// File: doc/BRIEF.md
# Frame-Buffered Clocked Serial Port

This block is a clock-synchronous serial port that moves a whole multi-byte frame from one start command. Software first fills a 32-entry byte store through a simple write port, for example with an address byte, a command byte and some data bytes. It then sets the frame length and pulses start. From then on the engine shifts every byte out on the data-out pin and collects the bytes that arrive on the data-in pin, with no per-byte attention from the processor.

The transfer is full duplex. Each received byte replaces the slot whose contents have just been sent, so after the frame the store holds the incoming bytes in the order they arrived. The serial clock pin is shared. As clock master the port makes the clock from the system clock, with a period of twice the `HALF_PERIOD` parameter and at least six system cycles. As clock slave it follows an external clock, which it first passes through a two-flop synchroniser. The clock rests high. Data-out moves on a falling clock edge, data-in is captured on a rising edge, and bits go least significant first.

Top module: `fsio_port`

## Requirements
- R1: After reset, busy, done and irq are 0, sck_o and sdo are 1, and every buffer slot reads 0.
- R2: In master mode, sck_o stays high while no frame is running. During a frame it toggles once every HALF_PERIOD system cycles. The first toggle is a fall, HALF_PERIOD cycles after the start edge.
- R3: sdo changes only on a falling serial clock edge. For global bit j of the frame it presents bit (j mod 8) of slot (j div 8), least significant bit first.
- R4: sdi is captured on each rising serial clock edge. The eight bits captured for byte i are stored into slot i with the first bit received at bit 0, and can be read on rd_data.
- R5: frame_len_m1 is a 5-bit field holding the byte count minus one. A frame therefore carries 1 to 32 bytes, which is 8*(frame_len_m1+1) clock cycles, and it is captured when start is accepted.
- R6: busy rises at the clock edge that accepts start and falls at the edge of the last rising serial clock edge. done is high for exactly that one cycle, and irq is set at the same time. irq stays set until the next accepted start clears it.
- R7: While busy is high, a start pulse has no effect on the running frame, and buffer writes are dropped.
- R8: In slave mode, sck_oe is 0. The port takes its clock edges from sck_i after two synchroniser flops, with the same bit order, capture edge and frame end as in master mode.
- R9: In master mode, sck_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe (ignored while busy) |
| wr_addr | input | 5 | Buffer write slot |
| wr_data | input | 8 | Buffer write byte |
| rd_addr | input | 5 | Buffer read slot |
| rd_data | output | 8 | Buffer read byte (combinational) |
| frame_len_m1 | input | 5 | Frame byte count minus one |
| start | input | 1 | Start a frame when idle |
| slave_mode | input | 1 | 1: external clock, 0: internal clock |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Completion interrupt request, held until next start |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock driven to the pin |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench goes after the two length extremes, one byte and thirty-two bytes. A design that mis-decodes the count would stop one byte early or late, or wrap the slot index and overwrite slot 0. It sends a start pulse and buffer writes in the middle of a frame. A design that restarts would show a clock or busy mismatch on the next cycle, and one that accepts the write would return the new byte from an untouched slot. In master mode it compares the clock, data-out, busy, done and irq on every cycle, so a one-cycle slip in the half-period counter or in the edge on which data moves shows up at once. A slave frame checks that the synchronised clock, and not the internal generator, paces the shifting.

// File: rtl/fsio_pkg.sv
package fsio_pkg;

    localparam int BUF_BYTES = 32;
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int SYNC_FF   = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  slot_t;
    typedef logic [BIT_W-1:0]  bitpos_t;

    // serial clock edge events as seen in the system clock domain
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_evt_t;

    // frame progress
    typedef struct packed {
        logic    busy;
        slot_t   byte_idx;
        bitpos_t bit_idx;
        slot_t   last;
    } frame_t;

    function automatic logic is_last_bit(bitpos_t b);
        return b == bitpos_t'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/fsio_buf.sv
module fsio_buf
    import fsio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy_i,
    input  logic  sw_we_i,
    input  slot_t sw_addr_i,
    input  byte_t sw_data_i,
    input  logic  eng_we_i,
    input  slot_t eng_addr_i,
    input  byte_t eng_data_i,
    input  slot_t rd_addr_i,
    output byte_t rd_data_o,
    input  slot_t tx_addr_i,
    output byte_t tx_data_o
);

    logic [BUF_BYTES-1:0][BYTE_W-1:0] mem_q;
    logic [BUF_BYTES-1:0] eng_sel;
    logic [BUF_BYTES-1:0] sw_sel;

    // per-slot write decode; software loses to the engine and to busy
    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_dec
        assign eng_sel[g] = eng_we_i && (eng_addr_i == slot_t'(g));
        assign sw_sel[g]  = sw_we_i && !busy_i && (sw_addr_i == slot_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                if (eng_sel[i])
                    mem_q[i] <= eng_data_i;
                else if (sw_sel[i])
                    mem_q[i] <= sw_data_i;
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign tx_data_o = mem_q[tx_addr_i];

    // R7: no software write lands while a frame runs
    p_no_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !eng_we_i) |=> (mem_q == $past(mem_q)));

endmodule

// File: rtl/fsio_clk.sv
module fsio_clk
    import fsio_pkg::*;
#(
    parameter int HALF_PERIOD = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     busy_i,
    input  logic     slave_i,
    input  logic     sck_pin_i,
    output logic     sck_o,
    output sck_evt_t evt_o
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             sck_q;
    logic             tick;
    logic [SYNC_FF:0] sync_q;   // SYNC_FF stages plus one history flop

    assign tick = busy_i && !slave_i && (cnt_q == CNT_W'(HALF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (busy_i && !slave_i) begin
            if (tick) begin
                cnt_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_FF-1:0], sck_pin_i};
    end

    logic s_now, s_prev;
    assign s_now  = sync_q[SYNC_FF-1];
    assign s_prev = sync_q[SYNC_FF];

    always_comb begin
        if (slave_i) begin
            evt_o.fall = busy_i && s_prev && !s_now;
            evt_o.rise = busy_i && !s_prev && s_now;
        end else begin
            evt_o.fall = tick && sck_q;
            evt_o.rise = tick && !sck_q;
        end
    end

    assign sck_o = sck_q;

    // R2: the generated clock only moves on a master frame
    p_sck_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_i || slave_i) |=> sck_q);

endmodule

// File: rtl/fsio_engine.sv
module fsio_engine
    import fsio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  slot_t    len_m1_i,
    input  logic     slave_i,
    input  sck_evt_t evt_i,
    input  byte_t    tx_byte_i,
    input  logic     sdi_i,
    output logic     busy_o,
    output logic     done_o,
    output logic     irq_o,
    output logic     slave_q_o,
    output logic     sdo_o,
    output slot_t    slot_o,
    output logic     eng_we_o,
    output byte_t    eng_data_o
);

    frame_t fr;
    byte_t  rx_sr;
    logic   sdo_q, done_q, irq_q, slave_q;
    logic   byte_end;

    assign byte_end   = fr.busy && evt_i.rise && is_last_bit(fr.bit_idx);
    assign eng_we_o   = byte_end;
    assign eng_data_o = {sdi_i, rx_sr[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            fr      <= '0;
            rx_sr   <= '0;
            sdo_q   <= 1'b1;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
            slave_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!fr.busy) begin
                if (start_i) begin
                    fr.busy     <= 1'b1;
                    fr.byte_idx <= '0;
                    fr.bit_idx  <= '0;
                    fr.last     <= len_m1_i;
                    slave_q     <= slave_i;
                    irq_q       <= 1'b0;
                end
            end else begin
                if (evt_i.fall)
                    sdo_q <= tx_byte_i[fr.bit_idx];
                if (evt_i.rise) begin
                    rx_sr      <= {sdi_i, rx_sr[BYTE_W-1:1]};
                    fr.bit_idx <= fr.bit_idx + bitpos_t'(1);
                    if (byte_end) begin
                        if (fr.byte_idx == fr.last) begin
                            fr.busy <= 1'b0;
                            done_q  <= 1'b1;
                            irq_q   <= 1'b1;
                        end else begin
                            fr.byte_idx <= fr.byte_idx + slot_t'(1);
                        end
                    end
                end
            end
        end
    end

    assign busy_o    = fr.busy;
    assign done_o    = done_q;
    assign irq_o     = irq_q;
    assign slave_q_o = slave_q;
    assign sdo_o     = sdo_q;
    assign slot_o    = fr.byte_idx;

    // R6: done marks the cycle busy has just dropped
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!fr.busy && $past(fr.busy)));

    // R6: an accepted start clears the interrupt request
    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !fr.busy) |=> !irq_q);

    // R5: the slot index never passes the programmed count
    p_slot_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fr.busy |-> (fr.byte_idx <= fr.last));

endmodule

// File: rtl/fsio_port.sv
module fsio_port
    import fsio_pkg::*;
#(
    parameter int HALF_PERIOD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic [IDX_W-1:0] frame_len_m1,
    input  logic             start,
    input  logic             slave_mode,
    output logic             busy,
    output logic             done,
    output logic             irq,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    output logic             sdo,
    input  logic             sdi
);

    sck_evt_t evt;
    slot_t    slot;
    byte_t    tx_byte, eng_data;
    logic     eng_we, slave_q, sck_gen;

    fsio_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .busy_i     (busy),
        .sw_we_i    (wr_en),
        .sw_addr_i  (wr_addr),
        .sw_data_i  (wr_data),
        .eng_we_i   (eng_we),
        .eng_addr_i (slot),
        .eng_data_i (eng_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .tx_addr_i  (slot),
        .tx_data_o  (tx_byte)
    );

    fsio_clk #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .busy_i    (busy),
        .slave_i   (slave_q),
        .sck_pin_i (sck_i),
        .sck_o     (sck_gen),
        .evt_o     (evt)
    );

    fsio_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .len_m1_i   (frame_len_m1),
        .slave_i    (slave_mode),
        .evt_i      (evt),
        .tx_byte_i  (tx_byte),
        .sdi_i      (sdi),
        .busy_o     (busy),
        .done_o     (done),
        .irq_o      (irq),
        .slave_q_o  (slave_q),
        .sdo_o      (sdo),
        .slot_o     (slot),
        .eng_we_o   (eng_we),
        .eng_data_o (eng_data)
    );

    assign sck_o  = sck_gen;
    assign sck_oe = busy ? !slave_q : !slave_mode;

    // R2: master clock rests high between frames
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !slave_mode) |-> sck_o);

    // R3: in master frames data-out only moves together with a clock fall
    p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !slave_q && !$stable(sdo)) |-> $fell(sck_o));

    // R8: pin driver is off for an external-clock frame
    p_slave_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && slave_q) |-> !sck_oe);

endmodule

// File: tb/fsio_port_tb.sv
module fsio_port_tb;

    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] frame_len_m1 = '0;
    logic       start = 1'b0;
    logic       slave_mode = 1'b0;
    logic       busy, done, irq;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe, sdo;
    logic       sdi;
    logic       m_sdi = 1'b0;
    logic       s_sdi = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int done_cnt = 0;

    logic [7:0] tx_mem [32];
    logic [7:0] rx_pat [32];

    // reference model state
    bit cmp_en = 1'b0;
    bit m_busy, m_sck, m_sdo, m_done, m_irq;
    int m_k, m_nbits;

    assign sdi = slave_mode ? s_sdi : m_sdi;

    always #2.5 clk = ~clk;

    fsio_port #(.HALF_PERIOD(HALF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_len_m1(frame_len_m1),
        .start(start), .slave_mode(slave_mode), .busy(busy), .done(done), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
    );

    function automatic logic txbit(int j);
        return tx_mem[j/8][j%8];
    endfunction

    function automatic logic rxbit(int j);
        return rx_pat[j/8][j%8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural master-mode model, advanced on each rising system edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) done_cnt <= done_cnt + 1;
        m_done = 1'b0;
        if (rst) begin
            m_busy = 0; m_sck = 1; m_sdo = 1; m_irq = 0; m_k = 0;
        end else if (m_busy) begin
            m_k++;
            if (m_k % HALF == 0) begin
                int t;
                t = m_k / HALF;
                m_sck = ~m_sck;
                if (t % 2 == 1) begin
                    m_sdo = txbit((t - 1) / 2);
                    m_sdi <= rxbit((t - 1) / 2);
                end else if (t == 2 * m_nbits) begin
                    m_busy = 0; m_done = 1; m_irq = 1;
                end
            end
        end else if (start && !slave_mode) begin
            m_busy = 1; m_k = 0; m_irq = 0;
            m_nbits = 8 * (int'(frame_len_m1) + 1);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(busy == m_busy, "R6 busy", busy, m_busy);
            chk(done == m_done, "R6 done", done, m_done);
            chk(irq == m_irq, "R6 irq", irq, m_irq);
            chk(sck_o == m_sck, "R2 sck_o", sck_o, m_sck);
            chk(sdo == m_sdo, "R3 sdo", sdo, m_sdo);
            chk(sck_oe == 1'b1, "R9 sck_oe", sck_oe, 1);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = 5'(a);
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) wr(i, tx_mem[i]);
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        frame_len_m1 = 5'(len - 1);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic master_frame(input int len, input string req);
        load(len);
        pulse_start(len);
        wait_idle();
        for (int i = 0; i < len; i++) rd_chk(i, rx_pat[i], req);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            tx_mem[i] = 8'((i * 37 + 11) & 255);
            rx_pat[i] = 8'((i * 91 + 5) & 255) ^ 8'hA5;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && irq == 0, "R1 flags", {busy, done, irq}, 0);
        chk(sck_o == 1 && sdo == 1, "R1 pins", {sck_o, sdo}, 3);
        rd_chk(0, 8'h00, "R1 buffer");
        rd_chk(31, 8'h00, "R1 buffer");
        cmp_en = 1;

        // R4 R5: three-byte frame, bytes come back in arrival order
        master_frame(3, "R4 rx slot");
        chk(irq == 1, "R6 irq held", irq, 1);

        // R7: start and a write in the middle of a frame have no effect
        wr(5, 8'h5A);
        load(2);
        pulse_start(2);
        repeat (20) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wr(5, 8'hC3);
        wait_idle();
        rd_chk(5, 8'h5A, "R7 write dropped");
        rd_chk(1, rx_pat[1], "R7 frame length kept");

        // R5 boundaries: one byte and the full 32 bytes
        for (int i = 0; i < 32; i++) rx_pat[i] = rx_pat[i] ^ 8'h3C;
        master_frame(1, "R5 single byte");
        rd_chk(1, rx_pat[1] ^ 8'h3C, "R5 slot past end untouched");
        for (int i = 0; i < 32; i++) rx_pat[i] = ~rx_pat[i];
        master_frame(32, "R5 full frame");

        // R8: external clock frame
        cmp_en = 0;
        @(negedge clk);
        slave_mode = 1;
        load(2);
        for (int i = 0; i < 32; i++) rx_pat[i] = 8'(i * 13 + 7);
        begin
            int dc;
            dc = done_cnt;
            pulse_start(2);
            chk(irq == 0, "R6 irq cleared by start", irq, 0);
            chk(sck_oe == 0, "R8 sck_oe", sck_oe, 0);
            for (int j = 0; j < 16; j++) begin
                repeat (6) @(negedge clk);
                sck_i = 0; s_sdi = rxbit(j);
                repeat (6) @(negedge clk);
                chk(sdo == txbit(j), "R8 sdo", sdo, txbit(j));
                chk(busy == 1, "R8 busy", busy, 1);
                sck_i = 1;
            end
            repeat (6) @(negedge clk);
            chk(done_cnt == dc + 1, "R8 one done", done_cnt, dc + 1);
            chk(busy == 0 && irq == 1, "R8 end", {busy, irq}, 1);
            chk(sck_o == 1, "R8 sck_o undriven high", sck_o, 1);
        end
        rd_chk(0, rx_pat[0], "R8 rx slot");
        rd_chk(1, rx_pat[1], "R8 rx slot");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule